// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the 32-bit program counter of a single-cycle processor and chooses its successor on every rising clock edge. The choice is made from the instruction word being executed, two control strobes from the main decoder (a conditional-branch request and an unconditional-jump request), and the equality flag coming from the ALU. The registered PC is the block's only output and serves as the instruction-memory address.

Three successors are possible. The default is the address of the next word, PC+4. A conditional branch adds the sign-extended 16-bit offset, scaled by four, to PC+4, and is taken only when the branch strobe and the equality flag are both high. A jump stays inside the current 256 MB region: the top four bits come from PC+4, and the 26-bit target field of the instruction, shifted left by two, fills the rest. The jump selector sits after the branch selector, so a jump always wins. A synchronous active-high reset sets the PC to zero.

Top module: `pc_seq_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` becomes 32'h0000_0000 on that edge, whatever the other inputs are.
- R2: With `br_req` and `jmp_req` low, each clock edge out of reset loads `pc_q` with the old `pc_q` + 4, modulo 2^32.
- R3: With `br_req` high, `alu_zero` high and `jmp_req` low, the next `pc_q` is old `pc_q` + 4 + (sign-extended `instr_word[15:0]` << 2), modulo 2^32. Bit 15 is the sign bit, so negative offsets branch backward.
- R4: With `br_req` high but `alu_zero` low, and `jmp_req` low, the branch is not taken and the next `pc_q` is old `pc_q` + 4.
- R5: With `alu_zero` high but `br_req` low, and `jmp_req` low, the next `pc_q` is old `pc_q` + 4.
- R6: With `jmp_req` high, the next `pc_q` is {(old `pc_q` + 4)[31:28], `instr_word[25:0]`, 2'b00}. Bits [31:26] of the instruction have no effect.
- R7: When `jmp_req` is high, the values of `br_req` and `alu_zero` do not change the next `pc_q`.
- R8: The two low bits of `pc_q` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 32 | Instruction currently executing |
| br_req | input | 1 | Conditional branch strobe from the decoder |
| jmp_req | input | 1 | Unconditional jump strobe from the decoder |
| alu_zero | input | 1 | ALU equality flag (result was zero) |
| pc_q | output | 32 | Current program counter |

## Verification
The PC is the only state, so any error in the selection or arithmetic shows on `pc_q` one edge after the instruction that caused it. The error then stays visible, because every later address is computed from the wrong value. Each scenario sets a known PC through reset and straight-line steps, applies one control pattern, and compares `pc_q` after the following edge. Sign handling, the carry into the upper region bits during a jump, and the priority order are each exercised with operands where a wrong choice would give a different address.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

    localparam int ADDR_W   = 32;
    localparam int INSTR_W  = 32;
    localparam int IMM_W    = 16;
    localparam int TGT_W    = 26;
    localparam int STEP     = 4;
    localparam int ALIGN_W  = 2;
    localparam int REGION_W = ADDR_W - TGT_W - ALIGN_W;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        NX_SEQ    = 2'd0,
        NX_BRANCH = 2'd1,
        NX_JUMP   = 2'd2
    } nx_sel_e;

    typedef struct packed {
        addr_t seq;
        addr_t branch;
        addr_t jump;
    } nx_cand_t;

    function automatic addr_t scaled_offset(input logic [IMM_W-1:0] imm);
        addr_t ext;
        ext = addr_t'({{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm});
        return ext << ALIGN_W;
    endfunction

    function automatic addr_t region_target(input addr_t seq_pc,
                                            input logic [TGT_W-1:0] tgt);
        return {seq_pc[ADDR_W-1 -: REGION_W], tgt, {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/pc_target_gen.sv
module pc_target_gen
    import pc_seq_pkg::*;
(
    input  addr_t               pc_cur,
    input  logic [INSTR_W-1:0]  instr,
    output nx_cand_t            cand
);
    addr_t seq_w;

    always_comb begin
        seq_w       = pc_cur + addr_t'(STEP);
        cand.seq    = seq_w;
        cand.branch = seq_w + scaled_offset(instr[IMM_W-1:0]);
        cand.jump   = region_target(seq_w, instr[TGT_W-1:0]);
    end
endmodule

// File: rtl/pc_sel_logic.sv
module pc_sel_logic
    import pc_seq_pkg::*;
(
    input  logic     br_req,
    input  logic     jmp_req,
    input  logic     alu_zero,
    input  nx_cand_t cand,
    output nx_sel_e  sel,
    output addr_t    pc_next
);
    addr_t stage1;

    always_comb begin
        // first mux: branch vs sequential
        stage1 = (br_req && alu_zero) ? cand.branch : cand.seq;
        // second mux: jump overrides
        pc_next = jmp_req ? cand.jump : stage1;
        if (jmp_req)                 sel = NX_JUMP;
        else if (br_req && alu_zero) sel = NX_BRANCH;
        else                         sel = NX_SEQ;
    end
endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
    import pc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr_word,
    input  logic        br_req,
    input  logic        jmp_req,
    input  logic        alu_zero,
    output logic [31:0] pc_q
);
    addr_t    pc_r;
    addr_t    pc_nx;
    nx_cand_t cand;
    nx_sel_e  sel;

    pc_target_gen u_tgt (
        .pc_cur (pc_r),
        .instr  (instr_word),
        .cand   (cand)
    );

    pc_sel_logic u_sel (
        .br_req   (br_req),
        .jmp_req  (jmp_req),
        .alu_zero (alu_zero),
        .cand     (cand),
        .sel      (sel),
        .pc_next  (pc_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_r <= '0;
        else     pc_r <= pc_nx;
    end

    assign pc_q = pc_r;
endmodule

// File: rtl/pc_seq_unit_chk.sv
module pc_seq_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] instr_word,
    input logic        br_req,
    input logic        jmp_req,
    input logic        alu_zero,
    input logic [31:0] pc_q
);
    logic primed;
    always_ff @(posedge clk) primed <= 1'b1;

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (pc_q == 32'h0));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!br_req && !jmp_req) |=> (pc_q == $past(pc_q) + 32'd4));

    p_branch_taken_r3: assert property (@(posedge clk) disable iff (rst)
        (br_req && alu_zero && !jmp_req) |=>
        (pc_q == $past(pc_q) + 32'd4 +
                 {{14{$past(instr_word[15])}}, $past(instr_word[15:0]), 2'b00}));

    p_branch_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (br_req && !alu_zero && !jmp_req) |=> (pc_q == $past(pc_q) + 32'd4));

    p_zero_only_r5: assert property (@(posedge clk) disable iff (rst)
        (!br_req && alu_zero && !jmp_req) |=> (pc_q == $past(pc_q) + 32'd4));

    p_jump_target_r6: assert property (@(posedge clk) disable iff (rst)
        jmp_req |=> (pc_q[27:0] == {$past(instr_word[25:0]), 2'b00}));

    p_jump_region_r7: assert property (@(posedge clk) disable iff (rst)
        jmp_req |=> (pc_q[31:28] == ($past(pc_q) + 32'd4) >> 28));

    always @(negedge clk)
        if (primed) a_aligned_r8: assert (pc_q[1:0] == 2'b00);
endmodule

bind pc_seq_unit pc_seq_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr_word (instr_word),
    .br_req     (br_req),
    .jmp_req    (jmp_req),
    .alu_zero   (alu_zero),
    .pc_q       (pc_q)
);

// File: tb/pc_seq_unit_test.sv
module pc_seq_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr_word;
    logic        br_req, jmp_req, alu_zero;
    logic [31:0] pc_q;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pc_seq_unit uut (
        .clk(clk), .rst(rst), .instr_word(instr_word),
        .br_req(br_req), .jmp_req(jmp_req), .alu_zero(alu_zero), .pc_q(pc_q)
    );

    task automatic check(input string req, input logic [31:0] exp);
        n_cmp++;
        if (pc_q !== exp || pc_q[1:0] !== 2'b00) begin
            n_bad++;
            $display("FAIL %s: pc_q=%08h expected %08h", req, pc_q, exp);
        end
    endtask

    // drive inputs after negedge, one edge, sample at next negedge
    task automatic step(input logic b, input logic j, input logic z,
                        input logic [31:0] iw);
        br_req = b; jmp_req = j; alu_zero = z; instr_word = iw;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset", 32'h0);
        step(1'b0, 1'b0, 1'b0, 32'h0);
        step(1'b0, 1'b0, 1'b0, 32'h0);
        rst = 1'b1;
        step(1'b0, 1'b1, 1'b0, 32'h0);
        rst = 1'b0;
        check("R1 reset mid-run", 32'h0);
    endtask

    task automatic t_seq();
        do_reset();
        for (int i = 1; i <= 5; i++) begin
            step(1'b0, 1'b0, 1'b0, 32'h1234_5678);
            check("R2 sequential", 32'(i * 4));
        end
    endtask

    task automatic t_branch();
        logic [31:0] e;
        do_reset();
        step(1'b0, 1'b0, 1'b0, 0);                  // pc=4
        step(1'b1, 1'b0, 1'b1, 32'h1000_0010);      // +4+0x40
        e = 32'h48;
        check("R3 forward branch", e);
        step(1'b1, 1'b0, 1'b1, 32'h0000_FFF0);      // -0x40
        e = e + 4 - 32'h40;
        check("R3 backward branch", e);
        step(1'b1, 1'b0, 1'b1, 32'h0000_FFFE);      // -8 -> e-4
        e = e - 4;
        check("R3 branch -2 words", e);
    endtask

    task automatic t_branch_not();
        do_reset();
        step(1'b1, 1'b0, 1'b0, 32'h0000_0100);
        check("R4 branch not equal", 32'h4);
        step(1'b0, 1'b0, 1'b1, 32'h0000_0100);
        check("R5 zero without branch", 32'h8);
    endtask

    task automatic t_jump();
        do_reset();
        step(1'b0, 1'b1, 1'b0, 32'hFC00_0123);
        check("R6 jump opcode bits ignored", 32'h0000_048C);
        step(1'b0, 1'b1, 1'b0, 32'h03FF_FFFF);
        check("R6 jump max field", 32'h0FFF_FFFC);
        // pc=0x0FFFFFFC, pc+4 crosses into region 1
        step(1'b0, 1'b1, 1'b0, 32'h0000_0004);
        check("R6 jump region from pc+4", 32'h1000_0010);
    endtask

    task automatic t_priority();
        do_reset();
        step(1'b1, 1'b1, 1'b1, 32'h0000_0040);
        check("R7 jump beats taken branch", 32'h0000_0100);
        step(1'b1, 1'b1, 1'b0, 32'h0000_0080);
        check("R7 jump with branch not taken", 32'h0000_0200);
    endtask

    initial begin
        rst = 1'b1; br_req = 0; jmp_req = 0; alu_zero = 0; instr_word = 0;
        @(negedge clk);
        t_reset();
        t_seq();
        t_branch();
        t_branch_not();
        t_jump();
        t_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule